// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps a two-rank DDR SDRAM refreshed. A free-running prescaler turns the clock into refresh credits. The credits are spaced so that the required number of auto-refresh commands fits inside each data-retention window. Whenever a credit is waiting, the block takes the command bus. It closes any open rows with a precharge-all, waits the row-precharge time, and then sends an auto-refresh to both ranks in the same cycle.

The block also handles self-refresh. While the request input is high and no credit is waiting, it idles the banks, issues the refresh encoding with clock enable low, and holds clock enable low. When the request drops, it raises clock enable and keeps the bus quiet for the exit delay. Credits that build up while the bus is unavailable are counted up to a fixed limit and then issued back to back.

The busy output tells the normal command path to hold off. All DRAM timing values are given as parameters in clock cycles, except the refresh interval, which is computed from the window length, the refresh count and the clock period.

Top module: `refresh_sched`

## Requirements
- R1: While reset is low, and at the first sample after it is released, clock enable is high, both chip selects are high (NOP) and busy is low.
- R2: One refresh credit is earned every TREFI = WINDOW_NS / (REFS * CLK_NS) cycles. Each credit produces exactly one auto-refresh, and the phase of the credits does not drift.
- R3: Every command the block drives has both chip-select lines low at the same time. Chip selects 2'b11 means no command.
- R4: The encodings are {ras_n, cas_n, we_n} = 0,0,1 for refresh and 0,1,0 for precharge. A precharge always carries address bit 8 high, which selects all banks.
- R5: If the bank-open input is high when the bus is taken, a precharge-all comes first. The next command (refresh or self-refresh entry) follows exactly TRP cycles later.
- R6: After a refresh, no command of any kind is driven for at least TRFC cycles.
- R7: Busy is low when idle and high from the cycle a credit is pending. It stays high through every command the block drives.
- R8: Pending credits saturate at MAX_PEND. A backlog is drained as consecutive refreshes spaced exactly TRFC cycles apart.
- R9: A self-refresh request with no credit pending leads to the refresh encoding driven with clock enable low. Clock enable then stays low, with no commands, for as long as the request is held.
- R10: When the request drops, clock enable rises and no command is driven for at least TXSR cycles after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req | input | 1 | Self-refresh request, held high for the whole stay |
| bank_open | input | 1 | High when any bank has an open row |
| cs_n | output | 2 | Chip selects, one per rank, active low |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| a8 | output | 1 | Address bit 8 (all-bank precharge) |
| cke | output | 1 | Clock enable |
| busy | output | 1 | Holds off normal commands |

## Verification
If the credit counter loses or invents a credit, the number of refreshes changes. This shows up within one interval as a missing or extra command, or after a self-refresh stay as a backlog burst of the wrong length. A wrong wait count in the sequencer moves the next command off its exact TRP or TRFC spacing in the same sequence. A stuck or early clock-enable state is seen at the next sample through the clock-enable pin or a command inside the quiet window. The bench compares each observed command with an expected kind in order and measures the cycles between commands.

// File: rtl/rr_pkg.sv
package rr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_RP, ST_REF, ST_RFC, ST_SRE, ST_SR, ST_XS
  } rr_state_e;

  typedef struct packed {
    logic [1:0] cs_n;
    logic       ras_n;
    logic       cas_n;
    logic       we_n;
    logic       a8;
  } rr_cmd_t;

  localparam rr_cmd_t CMD_NOP = '{2'b11, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam rr_cmd_t CMD_PRE = '{2'b00, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam rr_cmd_t CMD_REF = '{2'b00, 1'b0, 1'b0, 1'b1, 1'b0};

  // cycles between refresh credits
  function automatic int unsigned refi_cycles(int unsigned window_ns,
                                              int unsigned refs,
                                              int unsigned clk_ns);
    return window_ns / (refs * clk_ns);
  endfunction

  // bits needed to hold values 0..n
  function automatic int unsigned hold_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rr_tick.sv
module rr_tick #(
  parameter int unsigned TREFI = 1562
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = rr_pkg::hold_bits(TREFI - 1);

  logic [W-1:0] phase;

  assign tick = (phase == W'(TREFI - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + 1'b1;
  end

  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/rr_pend.sv
module rr_pend #(
  parameter int unsigned MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic earn,
  input  logic spend,
  output logic any
);
  localparam int unsigned W = rr_pkg::hold_bits(MAX_PEND);

  logic [W-1:0] credits;
  logic         full;

  assign full = (credits == W'(MAX_PEND));
  assign any  = (credits != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) credits <= '0;
    else if (earn && !spend && !full) credits <= credits + 1'b1;
    else if (spend && !earn && any)   credits <= credits - 1'b1;
  end

  p_pend_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    credits <= W'(MAX_PEND));

endmodule

// File: rtl/rr_seq.sv
module rr_seq
  import rr_pkg::*;
#(
  parameter int unsigned TRP  = 3,
  parameter int unsigned TRFC = 14,
  parameter int unsigned TXSR = 40
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pend_any,
  input  logic      sr_req,
  input  logic      bank_open,
  output rr_state_e state,
  output rr_cmd_t   cmd,
  output logic      cke,
  output logic      ref_go
);
  localparam int unsigned TMAX = (TRP > TRFC) ? ((TRP > TXSR) ? TRP : TXSR)
                                             : ((TRFC > TXSR) ? TRFC : TXSR);
  localparam int unsigned CW = hold_bits(TMAX);

  rr_state_e      nxt;
  logic [CW-1:0]  wait_cnt, wait_nxt;
  logic           wait_done;

  assign wait_done = (wait_cnt == CW'(1));

  always_comb begin
    nxt      = state;
    wait_nxt = (wait_cnt != '0) ? wait_cnt - 1'b1 : wait_cnt;
    unique case (state)
      ST_IDLE: begin
        if (pend_any)    nxt = bank_open ? ST_PRE : ST_REF;
        else if (sr_req) nxt = bank_open ? ST_PRE : ST_SRE;
      end
      ST_PRE: begin
        nxt = ST_RP;
        wait_nxt = CW'(TRP - 1);
      end
      ST_RP: if (wait_done) nxt = pend_any ? ST_REF : (sr_req ? ST_SRE : ST_IDLE);
      ST_REF: begin
        nxt = ST_RFC;
        wait_nxt = CW'(TRFC - 1);
      end
      ST_RFC: if (wait_done) nxt = pend_any ? ST_REF : ST_IDLE;
      ST_SRE: nxt = ST_SR;
      ST_SR: if (!sr_req) begin
        nxt = ST_XS;
        wait_nxt = CW'(TXSR - 1);
      end
      ST_XS: if (wait_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wait_cnt <= '0;
    end else begin
      state    <= nxt;
      wait_cnt <= wait_nxt;
    end
  end

  always_comb begin
    unique case (state)
      ST_PRE:         cmd = CMD_PRE;
      ST_REF, ST_SRE: cmd = CMD_REF;
      default:        cmd = CMD_NOP;
    endcase
  end

  assign cke    = !(state == ST_SRE || state == ST_SR);
  assign ref_go = (state == ST_REF);

  p_exit_cke_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SR && !sr_req) |=> cke);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import rr_pkg::*;
#(
  parameter int unsigned CLK_NS    = 5,
  parameter int unsigned WINDOW_NS = 32_000_000,
  parameter int unsigned REFS      = 4096,
  parameter int unsigned TRP       = 3,
  parameter int unsigned TRFC      = 14,
  parameter int unsigned TXSR      = 40,
  parameter int unsigned MAX_PEND  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_req,
  input  logic       bank_open,
  output logic [1:0] cs_n,
  output logic       ras_n,
  output logic       cas_n,
  output logic       we_n,
  output logic       a8,
  output logic       cke,
  output logic       busy
);
  localparam int unsigned TREFI = refi_cycles(WINDOW_NS, REFS, CLK_NS);

  logic      tick;
  logic      pend_any;
  logic      ref_go;
  rr_state_e state;
  rr_cmd_t   cmd;

  rr_tick #(.TREFI(TREFI)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rr_pend #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk(clk), .rst_n(rst_n), .earn(tick), .spend(ref_go), .any(pend_any)
  );

  rr_seq #(.TRP(TRP), .TRFC(TRFC), .TXSR(TXSR)) u_seq (
    .clk(clk), .rst_n(rst_n), .pend_any(pend_any), .sr_req(sr_req),
    .bank_open(bank_open), .state(state), .cmd(cmd), .cke(cke), .ref_go(ref_go)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
  assign a8    = cmd.a8;
  assign busy  = (state != ST_IDLE) || pend_any || sr_req;

  // observation counters for the timing checks below
  localparam int unsigned RW = hold_bits(TRFC);
  localparam int unsigned XW = hold_bits(TXSR);

  logic          cmd_valid;
  logic [RW-1:0] since_ref;
  logic [XW-1:0] since_up;

  assign cmd_valid = (cs_n != 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_ref <= RW'(TRFC);
      since_up  <= XW'(TXSR);
    end else begin
      if (cmd_valid && !ras_n && !cas_n) since_ref <= RW'(1);
      else if (since_ref < RW'(TRFC))    since_ref <= since_ref + 1'b1;
      if (!cke)                          since_up  <= '0;
      else if (since_up < XW'(TXSR))     since_up  <= since_up + 1'b1;
    end
  end

  p_ref_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> since_ref >= RW'(TRFC));

  p_exit_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cke) |-> since_up >= XW'(TXSR));

  p_busy_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  p_sre_enc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cs_n == 2'b00 && !ras_n && !cas_n && we_n));

  p_pair_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> cs_n == 2'b00);

  p_pre_a8_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ras_n && cas_n && !we_n) |-> a8);

endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_NS = 5, WINDOW_NS = 4000, REFS = 16;
  localparam int TREFI = WINDOW_NS / (REFS * CLK_NS);   // 50
  localparam int TRP = 3, TRFC = 6, TXSR = 8, MAX_PEND = 4;
  localparam int K_REF = 0, K_PRE = 1, K_SRE = 2, K_BAD = 3;

  logic clk = 0, rst_n = 0, sr_req = 0, bank_open = 0;
  logic [1:0] cs_n;
  logic ras_n, cas_n, we_n, a8, cke, busy;

  refresh_sched #(.CLK_NS(CLK_NS), .WINDOW_NS(WINDOW_NS), .REFS(REFS),
    .TRP(TRP), .TRFC(TRFC), .TXSR(TXSR), .MAX_PEND(MAX_PEND)) uut (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .bank_open(bank_open),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a8(a8),
    .cke(cke), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, errors = 0, checks = 0;
  int expq[$];
  int obs_cyc[$];
  int last_kind = -1, last_cyc = 0, rise_cyc = -1000;
  logic prev_cke = 1'b1;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: pops expected command kinds and measures spacing
  always @(negedge clk) begin
    if (rst_n) begin
      if (cke && !prev_cke) rise_cyc = cyc;
      prev_cke = cke;
      if (cs_n != 2'b11) begin
        int kind, exp_kind, gap;
        if (!ras_n && !cas_n && we_n) kind = cke ? K_REF : K_SRE;
        else if (!ras_n && cas_n && !we_n) kind = K_PRE;
        else kind = K_BAD;
        exp_kind = (expq.size() > 0) ? expq.pop_front() : -1;
        chk(kind == exp_kind, "R4", "command kind", kind, exp_kind);
        chk(cs_n == 2'b00, "R3", "both chip selects low", cs_n, 0);
        chk(busy, "R7", "busy during command", busy, 1);
        if (kind == K_PRE) chk(a8, "R4", "a8 on precharge", a8, 1);
        gap = cyc - last_cyc;
        if (last_kind == K_PRE) chk(gap == TRP, "R5", "precharge to next gap", gap, TRP);
        if (last_kind == K_REF) chk(gap >= TRFC, "R6", "refresh to next gap", gap, TRFC);
        if (kind == K_REF && cyc - rise_cyc < 3 * TXSR)
          chk(cyc - rise_cyc >= TXSR, "R10", "quiet after exit", cyc - rise_cyc, TXSR);
        last_kind = kind;
        last_cyc  = cyc;
        obs_cyc.push_back(cyc);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    chk(1'b0, "R2", "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cke == 1'b1, "R1", "cke in reset", cke, 1);
    chk(cs_n == 2'b11, "R1", "chip selects in reset", cs_n, 3);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cke == 1'b1 && cs_n == 2'b11 && !busy, "R1", "idle after reset", {cke, cs_n, busy}, 4'b1110);

    // two plain refreshes with rows closed
    expq.push_back(K_REF);
    expq.push_back(K_REF);
    wait_cyc(TREFI - 1);
    chk(busy == 1'b0, "R7", "busy before first credit", busy, 0);
    wait_cyc(TREFI);
    chk(busy == 1'b1, "R7", "busy once credit pending", busy, 1);
    wait_cyc(120);
    chk(busy == 1'b0, "R7", "busy released when idle", busy, 0);

    // refresh with an open row: precharge-all first
    bank_open = 1'b1;
    expq.push_back(K_PRE);
    expq.push_back(K_REF);
    wait_cyc(165);

    // self-refresh with an open row
    expq.push_back(K_PRE);
    expq.push_back(K_SRE);
    sr_req = 1'b1;
    wait_cyc(175);
    bank_open = 1'b0;
    wait_cyc(300);
    chk(cke == 1'b0, "R9", "cke low while held", cke, 0);
    chk(cs_n == 2'b11, "R9", "no command in self-refresh", cs_n, 3);

    // exit; backlog saturates at MAX_PEND
    for (int i = 0; i < MAX_PEND; i++) expq.push_back(K_REF);
    expq.push_back(K_REF);
    wait_cyc(2 * TREFI * 4 + 2);
    sr_req = 1'b0;
    wait_cyc(2 * TREFI * 4 + 4);
    chk(cke == 1'b1, "R10", "cke raised after request drop", cke, 1);
    chk(cs_n == 2'b11, "R10", "bus quiet after exit", cs_n, 3);
    wait_cyc(470);

    chk(expq.size() == 0, "R2", "expected commands left", expq.size(), 0);
    chk(obs_cyc.size() == 11, "R8", "total commands", obs_cyc.size(), 11);
    if (obs_cyc.size() == 11) begin
      chk(obs_cyc[1] - obs_cyc[0] == TREFI, "R2", "credit interval", obs_cyc[1] - obs_cyc[0], TREFI);
      chk(obs_cyc[10] - obs_cyc[1] == 7 * TREFI, "R2", "credit phase kept",
          obs_cyc[10] - obs_cyc[1], 7 * TREFI);
      for (int i = 7; i <= 9; i++)
        chk(obs_cyc[i] - obs_cyc[i-1] == TRFC, "R8", "backlog spacing",
            obs_cyc[i] - obs_cyc[i-1], TRFC);
    end
    chk(busy == 1'b0, "R7", "busy at end", busy, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule